// File: doc/BRIEF.md
# Binary32 to Binary16 Narrowing Converter

This block takes one single-precision word and returns the half-precision value nearest to it under the selected rounding direction. It is built as a single datapath. The datapath classifies the input exponent into one of six regions: special, overflow, normal, subnormal, exact zero and underflow. Each region produces its own candidate result, and a final select picks one. The normal and subnormal regions share one rounding-increment function. That function sees the sign, the retained least significant bit, a guard bit and a sticky bit, and decides whether the truncated magnitude steps up by one unit in the last place.

A three-bit mode input chooses among five rounding directions. The overflow and underflow regions do not round. Each picks a saturation constant from the sign and the rounding direction. A NaN input stays a NaN, and a fixed mantissa bit is forced on so that a payload held only in the low bits cannot turn into infinity. Optional input and output registers are set by parameters. By default only the output is registered, so a result appears one clock after its operands.

Top module: `f32_to_f16_round`

## Requirements
- R1: The mode encoding is 0 round toward +infinity, 1 round toward -infinity, 2 round toward zero, 3 nearest with ties to the even value, and 4 nearest with ties away from zero. Codes 5, 6 and 7 give exactly the same results as code 3.
- R2: An input with biased exponent 113 to 142 yields a normal result. The output exponent is the input exponent minus 112. Bits 22..13 of the input fraction become the mantissa, and the 13 dropped bits round per mode. For example, 0x3F801000 gives 0x3C00 in mode 3 and 0x3C01 in mode 4, and 0x3F803000 gives 0x3C02 in mode 3.
- R3: A rounding carry out of the mantissa raises the exponent, and at the top of the range it produces infinity. For example, 0x477FF000 (65520) gives 0x7C00 in modes 0, 3 and 4 and 0x7BFF in modes 1 and 2, while 0x477FEF00 (65519) gives 0x7BFF in mode 3.
- R4: An input with exponent 143 to 254 saturates. A positive input gives 0x7C00 in modes 0, 3 and 4 and 0x7BFF in modes 1 and 2. A negative input gives 0xFC00 in modes 1, 3 and 4 and 0xFBFF in modes 0 and 2.
- R5: An input with exponent 101 to 112 yields a subnormal result. The result is the fraction with its hidden one shifted right by 126 minus the exponent, rounded per mode, and it may round up to the smallest normal 0x0400. For example, 0x387FC000 gives 0x03FF and 0x387FE000 gives 0x0400 in mode 3.
- R6: A non-zero input with exponent 1 to 100, or with exponent 0, underflows. A positive input gives 0x0001 in mode 0 and 0x0000 otherwise. A negative input gives 0x8001 in mode 1 and 0x8000 otherwise.
- R7: An exact zero of either sign maps to the zero of the same sign (0x0000 or 0x8000) in every mode.
- R8: An input with exponent 255 and a zero fraction gives a signed infinity (0x7C00 or 0xFC00). An input with exponent 255 and a non-zero fraction gives exponent 31, output bit 9 set, and output bits 8..0 equal to input fraction bits 21..13.
- R9: Output bit 15 always equals input bit 31.
- R10: While reset is asserted the output is 0x0000. With the default parameters the result for the inputs present at a rising clock edge appears on the output after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Single-precision operand |
| rmode | input | 3 | Rounding direction select |
| dout | output | 16 | Half-precision result |

## Verification
The in-module properties check, on every cycle, facts that hold for any input in a given exponent region. These are: sign preservation, NaN quieting, exact zero mapping, underflow magnitude no larger than one unit, subnormal results no larger than the smallest normal, normal results staying finite, and round-toward-zero overflow capping at the largest finite value. Those properties cannot show that a given result is the correctly rounded value. Only the bench scenarios can show that: tie handling, the 65519/65520 boundary, subnormal rounding into the normal range, and the direction of saturation for each sign. They sweep every input exponent with a set of fraction patterns in all eight mode codes, then compare random words against an arithmetic model built on real numbers.

// File: rtl/f32_to_f16_round.sv
module f32_to_f16_round #(
  parameter bit IN_REG  = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] din,
  input  logic [2:0]  rmode,
  output logic [15:0] dout
);

  localparam logic [2:0] M_UP  = 3'd0;
  localparam logic [2:0] M_DN  = 3'd1;
  localparam logic [2:0] M_RZ  = 3'd2;
  localparam logic [2:0] M_RNE = 3'd3;
  localparam logic [2:0] M_RNA = 3'd4;

  localparam logic [7:0] EXP_SUB_LO  = 8'd101;
  localparam logic [7:0] EXP_NORM_LO = 8'd113;
  localparam logic [7:0] EXP_OVF_LO  = 8'd143;
  localparam logic [7:0] EXP_TOP     = 8'd255;

  localparam logic [14:0] MAG_INF = 15'h7C00;
  localparam logic [14:0] MAG_MAX = 15'h7BFF;

  typedef enum logic [2:0] {
    C_SPECIAL, C_OVER, C_NORM, C_SUB, C_ZERO, C_UNDER
  } region_t;

  logic [31:0] x;
  logic [2:0]  xm;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          x  <= '0;
          xm <= '0;
        end else begin
          x  <= din;
          xm <= rmode;
        end
      end
    end else begin : g_in_pass
      assign x  = din;
      assign xm = rmode;
    end
  endgenerate

  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] fr;
  logic [2:0]  md;

  assign sgn = x[31];
  assign ex  = x[30:23];
  assign fr  = x[22:0];
  assign md  = (xm > M_RNA) ? M_RNE : xm;

  function automatic logic bump(input logic [2:0] m, input logic s,
                                input logic lsb, input logic g, input logic st);
    case (m)
      M_UP:    bump = !s && (g || st);
      M_DN:    bump = s && (g || st);
      M_RZ:    bump = 1'b0;
      M_RNA:   bump = g;
      default: bump = g && (st || lsb);
    endcase
  endfunction

  region_t cls;

  always_comb begin
    if (ex == EXP_TOP)                cls = C_SPECIAL;
    else if (ex >= EXP_OVF_LO)        cls = C_OVER;
    else if (ex >= EXP_NORM_LO)       cls = C_NORM;
    else if (ex >= EXP_SUB_LO)        cls = C_SUB;
    else if (ex == 8'd0 && fr == '0)  cls = C_ZERO;
    else                              cls = C_UNDER;
  end

  logic [4:0]  n_exp;
  logic        n_inc;
  logic [14:0] n_mag;

  assign n_exp = ex[4:0] - 5'd16;
  assign n_inc = bump(md, sgn, fr[13], fr[12], |fr[11:0]);
  assign n_mag = {n_exp, fr[22:13]} + {14'd0, n_inc};

  logic [3:0]  s_sh;
  logic [35:0] s_win;
  logic        s_inc;
  logic [14:0] s_mag;

  assign s_sh  = 4'd0 - ex[3:0];
  assign s_win = {1'b1, fr, 12'd0} >> s_sh;
  assign s_inc = bump(md, sgn, s_win[26], s_win[25], |s_win[24:0]);
  assign s_mag = {5'd0, s_win[35:26]} + {14'd0, s_inc};

  logic to_inf;
  logic tiny_up;

  assign to_inf  = (md == M_RNE) || (md == M_RNA) ||
                   (md == M_UP && !sgn) || (md == M_DN && sgn);
  assign tiny_up = (md == M_UP && !sgn) || (md == M_DN && sgn);

  logic [14:0] mag;

  always_comb begin
    case (cls)
      C_SPECIAL: mag = (fr == '0) ? MAG_INF : {5'h1F, 1'b1, fr[21:13]};
      C_OVER:    mag = to_inf ? MAG_INF : MAG_MAX;
      C_NORM:    mag = n_mag;
      C_SUB:     mag = s_mag;
      C_ZERO:    mag = '0;
      default:   mag = {14'd0, tiny_up};
    endcase
  end

  logic [15:0] y;
  assign y = {sgn, mag};

  generate
    if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= y;
      end
    end else begin : g_out_pass
      assign dout = y;
    end
  endgenerate

  p_sign_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    y[15] == x[31]);

  p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (x[30:23] == 8'hFF && x[22:0] != '0) |-> (y[14:10] == 5'h1F && y[9]));

  p_zero_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (x[30:0] == '0) |-> (y[14:0] == '0));

  p_rz_caps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (x[30:23] >= EXP_OVF_LO && x[30:23] != EXP_TOP && xm == M_RZ) |-> (y[14:0] == MAG_MAX));

  p_under_tiny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (x[30:23] < EXP_SUB_LO) |-> (y[14:1] == '0));

  p_sub_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (x[30:23] >= EXP_SUB_LO && x[30:23] < EXP_NORM_LO) |-> (y[14:0] <= 15'h0400));

  p_norm_finite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x[30:23] >= EXP_NORM_LO && x[30:23] < 8'd142) |-> (y[14:10] != 5'h00 && y[14:10] != 5'h1F));

endmodule

// File: tb/f32_to_f16_round_tb.sv
`timescale 1ns/1ps
module f32_to_f16_round_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [2:0]  rmode = '0;
  logic [15:0] dout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  f32_to_f16_round u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .rmode(rmode), .dout(dout)
  );

  function automatic logic [15:0] ref16(input logic [31:0] w, input logic [2:0] mi);
    logic s;
    int   e, f, m, n, lo, code, eb;
    real  a, ulp, q, fl, fr, p;
    bit   up, inex;
    s = w[31];
    e = int'(w[30:23]);
    f = int'(w[22:0]);
    m = (mi > 3'd4) ? 3 : int'(mi);
    if (e == 255) return (f == 0) ? {s, 15'h7C00} : {s, 5'h1F, 1'b1, w[21:13]};
    a = (e == 0) ? real'(f) : real'(f + 8388608);
    n = ((e == 0) ? 1 : e) - 150;
    if (n > 0) for (int k = 0; k < n; k++) a = a * 2.0;
    else       for (int k = 0; k < -n; k++) a = a / 2.0;
    if (a == 0.0) return {s, 15'h0000};
    if (a >= 65536.0) begin
      code = 16'h7BFF; lo = 1; fr = 0.75;
    end else if (a < 1.0 / 16384.0) begin
      ulp = 1.0 / 16777216.0;
      q = a / ulp; fl = $floor(q); lo = int'(fl); fr = q - fl;
      code = lo;
    end else begin
      p = 1.0 / 16384.0; eb = 1;
      while (p * 2.0 <= a) begin p = p * 2.0; eb++; end
      ulp = p / 1024.0;
      q = a / ulp; fl = $floor(q); lo = int'(fl); fr = q - fl;
      code = eb * 1024 + lo - 1024;
    end
    inex = (fr > 0.0);
    case (m)
      0: up = inex && !s;
      1: up = inex && s;
      2: up = 1'b0;
      4: up = (fr >= 0.5);
      default: up = (fr > 0.5) || (fr == 0.5 && (code % 2 == 1));
    endcase
    code = code + int'(up);
    return {s, code[14:0]};
  endfunction

  function automatic string req_for(input logic [31:0] w, input logic [2:0] m);
    int e;
    e = int'(w[30:23]);
    if (m > 3'd4)           return "R1";
    if (e == 255)           return "R8";
    if (w[30:0] == '0)      return "R7";
    if (e >= 143)           return "R4";
    if (e == 142)           return "R3";
    if (e >= 113)           return "R2";
    if (e >= 101)           return "R5";
    return "R6";
  endfunction

  task automatic apply(input logic [31:0] w, input logic [2:0] m,
                       input logic [15:0] exp, input string req);
    @(negedge clk);
    din = w; rmode = m;
    @(negedge clk);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: in=%h mode=%0d actual=%h expected=%h", req, w, m, dout, exp);
    end
  endtask

  function automatic logic [22:0] frac_pat(input int i);
    case (i)
      0: return 23'h000000;
      1: return 23'h7FFFFF;
      2: return 23'h000001;
      3: return 23'h400000;
      4: return 23'h001000;
      5: return 23'h003000;
      6: return 23'h002FFF;
      7: return 23'h7FF000;
      default: return 23'($urandom);
    endcase
  endfunction

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== 16'h0000) begin
      errors++;
      $display("FAIL R10: reset output actual=%h expected=0000", dout);
    end
    rst_n = 1'b1;

    // R10: one-cycle latency, value visible after the capturing edge
    apply(32'h3C000000, 3'd3, 16'h2000, "R10");
    // R2 ties and rounding
    apply(32'h3F801000, 3'd3, 16'h3C00, "R2");
    apply(32'h3F801000, 3'd4, 16'h3C01, "R2");
    apply(32'h3F803000, 3'd3, 16'h3C02, "R2");
    apply(32'h3F801000, 3'd2, 16'h3C00, "R2");
    apply(32'h3F801000, 3'd0, 16'h3C01, "R2");
    // R3 65519 / 65520
    apply(32'h477FEF00, 3'd3, 16'h7BFF, "R3");
    apply(32'h477FF000, 3'd3, 16'h7C00, "R3");
    apply(32'h477FF000, 3'd4, 16'h7C00, "R3");
    apply(32'h477FF000, 3'd0, 16'h7C00, "R3");
    apply(32'h477FF000, 3'd1, 16'h7BFF, "R3");
    apply(32'h477FF000, 3'd2, 16'h7BFF, "R3");
    // R4 negative overflow per mode
    apply(32'hC8000000, 3'd0, 16'hFBFF, "R4");
    apply(32'hC8000000, 3'd1, 16'hFC00, "R4");
    apply(32'hC8000000, 3'd2, 16'hFBFF, "R4");
    // R5 largest subnormal, smallest normal, round into normal
    apply(32'h387FC000, 3'd3, 16'h03FF, "R5");
    apply(32'h38800000, 3'd3, 16'h0400, "R5");
    apply(32'h387FE000, 3'd3, 16'h0400, "R5");
    apply(32'h387FE000, 3'd2, 16'h03FF, "R5");
    // R6 underflow
    apply(32'h00000001, 3'd0, 16'h0001, "R6");
    apply(32'h80000001, 3'd1, 16'h8001, "R6");
    apply(32'h80000001, 3'd0, 16'h8000, "R6");
    // R7 signed zero, R8 NaN low payload, R9 sign
    apply(32'h80000000, 3'd0, 16'h8000, "R7");
    apply(32'h7F800001, 3'd3, 16'h7E00, "R8");
    apply(32'hFF800000, 3'd2, 16'hFC00, "R8");
    apply(32'hBFC00000, 3'd1, 16'hBE00, "R9");
    // R1 modes 5..7 equal to mode 3
    apply(32'h3F801000, 3'd5, 16'h3C00, "R1");
    apply(32'h3F803000, 3'd7, 16'h3C02, "R1");

    for (int e = 0; e < 256; e++)
      for (int fi = 0; fi < 9; fi++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 8; m++) begin
            w = {s[0], e[7:0], frac_pat(fi)};
            apply(w, m[2:0], ref16(w, m[2:0]), req_for(w, m[2:0]));
          end

    for (int i = 0; i < 8000; i++) begin
      w = $urandom;
      apply(w, 3'(i % 8), ref16(w, 3'(i % 8)), req_for(w, 3'(i % 8)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #950000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule